// File: doc/BRIEF.md
# Widening Signed Vector Shifter

This unit takes a packed vector of signed lanes, widens every lane to twice its width by sign extension and then shifts each widened lane left by an unsigned count. The widened lanes fill twice the width of the input vector, so the results leave the unit as two output vectors. One holds the lanes from the lower half of the input and the other holds the lanes from the upper half.

The shift count comes from one of two sources: an immediate count field or a register count operand. A single select input picks the source for each operation. Every operation also produces three summary flags. These are overflow, negative and zero. The unit is a fixed two-stage pipeline and can accept a new operation on every cycle. A valid bit travels alongside each operation so that results can be matched to requests.

Top module: `widen_shift_unit`

## Requirements
- R1: With a count of zero, each result lane equals the input lane sign-extended from LW to 2*LW bits. A negative lane fills the upper LW bits with ones; a non-negative lane fills them with zeros.
- R2: For a count c with 0 < c < 2*LW, each result lane holds the low 2*LW bits of the sign-extended lane shifted left by c. Zeros enter from the right. The count is read as unsigned.
- R3: When the effective count is 2*LW or larger, every result lane is zero.
- R4: When `sel_reg` is 0 the count is taken from `imm_cnt`. When `sel_reg` is 1 it is taken from `reg_cnt`. The count input that is not selected has no effect on any output.
- R5: Input lane i occupies bits [i*LW +: LW] of `in_vec`. For i < LANES/2 its result is at `out_lo[i*2*LW +: 2*LW]`. For the other lanes the result is at `out_hi[(i-LANES/2)*2*LW +: 2*LW]`.
- R6: An operation presented with `in_valid` high in cycle t has its results and flags on the outputs in cycle t+2, with `out_valid` high. `out_valid` is low in every cycle that is not two cycles after an accepted operation.
- R7: Operations presented on consecutive cycles each come out on consecutive cycles, in order, with no stall and no mixing.
- R8: `flag_ovf` is high when, for at least one lane, the exact product of the lane value and 2^c lies outside the signed 2*LW-bit range. With a count of 2*LW or more, this means any non-zero lane. The flag is never set when c <= LW.
- R9: `flag_zero` is high exactly when every result lane of the operation is zero.
- R10: `flag_neg` is high exactly when at least one result lane has its most significant bit set.
- R11: While `rst` is high at a clock edge, the unit clears `out_valid`, both output vectors and all flags after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An operation is presented this cycle |
| in_vec | input | LANES*LW | Packed signed input lanes |
| sel_reg | input | 1 | Count source: 0 immediate, 1 register |
| imm_cnt | input | CNT_W | Immediate shift count |
| reg_cnt | input | CNT_W | Register shift count |
| out_valid | output | 1 | Results and flags are valid |
| out_lo | output | LANES*LW | Widened results of the lower half of the lanes |
| out_hi | output | LANES*LW | Widened results of the upper half of the lanes |
| flag_ovf | output | 1 | Some lane lost significant bits |
| flag_neg | output | 1 | Some result lane is negative |
| flag_zero | output | 1 | All result lanes are zero |

## Verification
Mixed positive and negative lanes at a count of zero show whether sign extension fills the upper half correctly, and a wrong fill shows up only on the negative lanes. Moderate counts on the same lanes test the shift and the mapping of lanes into the two output vectors. Counts of LW, LW+1, 2*LW-1, 2*LW and the largest count probe the overflow boundary and the forced-zero region. An all-zero lane vector and a single 1 shifted into the sign bit separate the zero flag, the negative flag and the overflow flag from one another. Pairs of count values in which only the unselected source gives a different answer show whether the select input really ignores the other count. Back-to-back operations show whether one operation can leak data into the next.

// File: rtl/wsh_pkg.sv
package wsh_pkg;

    // Default geometry of the unit
    localparam int unsigned DEF_LANES = 4;
    localparam int unsigned DEF_LW    = 8;
    localparam int unsigned DEF_CNT_W = 6;

    // Source of the shift count
    typedef enum logic {
        CNT_FROM_IMM = 1'b0,
        CNT_FROM_REG = 1'b1
    } cnt_src_e;

    // Per-operation summary flags
    typedef struct packed {
        logic ovf;
        logic neg;
        logic zero;
    } wsh_flags_t;

    // Width of a shift amount that stays below 2*lw
    function automatic int unsigned amt_width(input int unsigned lw);
        return $clog2(2 * lw);
    endfunction

endpackage

// File: rtl/wsh_count_sel.sv
module wsh_count_sel
    import wsh_pkg::*;
#(
    parameter int unsigned LW    = DEF_LW,
    parameter int unsigned CNT_W = DEF_CNT_W,
    localparam int unsigned SH_W = amt_width(LW)
) (
    input  cnt_src_e         src,
    input  logic [CNT_W-1:0] imm_cnt,
    input  logic [CNT_W-1:0] reg_cnt,
    output logic [SH_W-1:0]  amt,
    output logic             kill
);

    logic [CNT_W-1:0] picked;
    logic [31:0]      picked_w;

    always_comb begin
        picked   = (src == CNT_FROM_REG) ? reg_cnt : imm_cnt;
        picked_w = 32'(picked);
        // Any count of the full widened width or more clears the lane
        kill     = (picked_w >= 32'(2 * LW));
        amt      = SH_W'(picked_w);
    end

endmodule

// File: rtl/wsh_lane.sv
module wsh_lane
    import wsh_pkg::*;
#(
    parameter int unsigned LW    = DEF_LW,
    localparam int unsigned SH_W = amt_width(LW),
    localparam int unsigned RW   = 2 * LW,
    localparam int unsigned XW   = 4 * LW
) (
    input  logic [LW-1:0]   x,
    input  logic [SH_W-1:0] amt,
    input  logic            kill,
    output logic [RW-1:0]   res,
    output logic            ovf
);

    logic [XW-1:0] ext;
    logic [XW-1:0] shifted;
    logic [RW:0]   spill;    // bits above the kept result plus its sign bit
    logic          fits;

    always_comb begin
        ext     = {{(XW - LW){x[LW-1]}}, x};
        shifted = ext << amt;
        spill   = shifted[XW-1:RW-1];
        fits    = (&spill) | ~(|spill);
        if (kill) begin
            res = '0;
            ovf = |x;
        end else begin
            res = shifted[RW-1:0];
            ovf = ~fits;
        end
    end

endmodule

// File: rtl/wsh_flag_reduce.sv
module wsh_flag_reduce
    import wsh_pkg::*;
#(
    parameter int unsigned LANES = DEF_LANES,
    parameter int unsigned LW    = DEF_LW,
    localparam int unsigned RW   = 2 * LW
) (
    input  logic [LANES*RW-1:0] res_all,
    input  logic [LANES-1:0]    lane_ovf,
    output wsh_flags_t          flags
);

    logic [LANES-1:0] lane_msb;

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            lane_msb[i] = res_all[i*RW + RW - 1];
        end
        flags.ovf  = |lane_ovf;
        flags.neg  = |lane_msb;
        flags.zero = ~(|res_all);
    end

endmodule

// File: rtl/widen_shift_unit.sv
module widen_shift_unit
    import wsh_pkg::*;
#(
    parameter int unsigned LANES = DEF_LANES,   // even
    parameter int unsigned LW    = DEF_LW,
    parameter int unsigned CNT_W = DEF_CNT_W    // at least amt_width(LW)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [LANES*LW-1:0] in_vec,
    input  logic                sel_reg,
    input  logic [CNT_W-1:0]    imm_cnt,
    input  logic [CNT_W-1:0]    reg_cnt,
    output logic                out_valid,
    output logic [LANES*LW-1:0] out_lo,
    output logic [LANES*LW-1:0] out_hi,
    output logic                flag_ovf,
    output logic                flag_neg,
    output logic                flag_zero
);

    localparam int unsigned SH_W  = amt_width(LW);
    localparam int unsigned RW    = 2 * LW;
    localparam int unsigned HALF  = LANES * LW;

    // Stage 1: operand capture with the count already resolved
    logic [SH_W-1:0]     c_amt;
    logic                c_kill;
    logic                s1_valid;
    logic [LANES*LW-1:0] s1_vec;
    logic [SH_W-1:0]     s1_amt;
    logic                s1_kill;

    wsh_count_sel #(.LW(LW), .CNT_W(CNT_W)) u_cnt (
        .src     (cnt_src_e'(sel_reg)),
        .imm_cnt (imm_cnt),
        .reg_cnt (reg_cnt),
        .amt     (c_amt),
        .kill    (c_kill)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_vec   <= '0;
            s1_amt   <= '0;
            s1_kill  <= 1'b0;
        end else begin
            s1_valid <= in_valid;
            s1_vec   <= in_vec;
            s1_amt   <= c_amt;
            s1_kill  <= c_kill;
        end
    end

    // Lane shifters
    logic [LANES*RW-1:0] res_all;
    logic [LANES-1:0]    lane_ovf;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        wsh_lane #(.LW(LW)) u_lane (
            .x    (s1_vec[g*LW +: LW]),
            .amt  (s1_amt),
            .kill (s1_kill),
            .res  (res_all[g*RW +: RW]),
            .ovf  (lane_ovf[g])
        );
    end

    wsh_flags_t c_flags;

    wsh_flag_reduce #(.LANES(LANES), .LW(LW)) u_flags (
        .res_all  (res_all),
        .lane_ovf (lane_ovf),
        .flags    (c_flags)
    );

    // Stage 2: result registers
    wsh_flags_t s2_flags;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_lo    <= '0;
            out_hi    <= '0;
            s2_flags  <= '0;
        end else begin
            out_valid <= s1_valid;
            out_lo    <= res_all[HALF-1:0];
            out_hi    <= res_all[2*HALF-1:HALF];
            s2_flags  <= c_flags;
        end
    end

    assign flag_ovf  = s2_flags.ovf;
    assign flag_neg  = s2_flags.neg;
    assign flag_zero = s2_flags.zero;

endmodule

// File: rtl/wsh_checker.sv
module wsh_checker
    import wsh_pkg::*;
#(
    parameter int unsigned LANES = DEF_LANES,
    parameter int unsigned LW    = DEF_LW,
    parameter int unsigned CNT_W = DEF_CNT_W
) (
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic [LANES*LW-1:0] in_vec,
    input logic                sel_reg,
    input logic [CNT_W-1:0]    imm_cnt,
    input logic [CNT_W-1:0]    reg_cnt,
    input logic                out_valid,
    input logic [LANES*LW-1:0] out_lo,
    input logic [LANES*LW-1:0] out_hi,
    input logic                flag_ovf,
    input logic                flag_neg,
    input logic                flag_zero
);

    logic [1:0]       since_rst;
    logic [CNT_W-1:0] eff_cnt;
    logic [31:0]      eff_w;

    always_ff @(posedge clk) begin
        if (rst)                 since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    always_comb begin
        eff_cnt = sel_reg ? reg_cnt : imm_cnt;
        eff_w   = 32'(eff_cnt);
    end

    assert_valid_latency_R6: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

    assert_large_count_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && eff_w >= 32'(2 * LW)) |-> ##2 (out_lo == '0 && out_hi == '0));

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && eff_w <= 32'(LW)) |-> ##2 !flag_ovf);

    assert_zero_flag_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && flag_zero) |-> (out_lo == '0 && out_hi == '0));

    assert_neg_not_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && flag_neg) |-> !flag_zero);

    assert_reset_clears_R11: assert property (@(posedge clk)
        rst |=> (!out_valid && !flag_ovf && !flag_neg));

endmodule

bind widen_shift_unit wsh_checker #(.LANES(LANES), .LW(LW), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_widen_shift_unit.sv
`timescale 1ns/1ps
module sim_widen_shift_unit;

    localparam int LANES = 4;
    localparam int LW    = 8;
    localparam int CNT_W = 6;
    localparam int RW    = 2 * LW;
    localparam int VW    = LANES * LW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [VW-1:0] in_vec = '0;
    logic          sel_reg = 1'b0;
    logic [CNT_W-1:0] imm_cnt = '0;
    logic [CNT_W-1:0] reg_cnt = '0;
    logic          out_valid;
    logic [VW-1:0] out_lo, out_hi;
    logic          flag_ovf, flag_neg, flag_zero;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    widen_shift_unit #(.LANES(LANES), .LW(LW), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_vec(in_vec),
        .sel_reg(sel_reg), .imm_cnt(imm_cnt), .reg_cnt(reg_cnt),
        .out_valid(out_valid), .out_lo(out_lo), .out_hi(out_hi),
        .flag_ovf(flag_ovf), .flag_neg(flag_neg), .flag_zero(flag_zero)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Independent arithmetic model of one operation
    task automatic model(input logic [VW-1:0] vec, input int c,
                         output logic [VW-1:0] lo, output logic [VW-1:0] hi,
                         output bit ovf, output bit neg, output bit zero);
        lo = '0; hi = '0; ovf = 0; neg = 0; zero = 1;
        for (int i = 0; i < LANES; i++) begin
            longint x = longint'($signed(vec[i*LW +: LW]));
            longint p;
            logic [RW-1:0] r;
            if (c >= RW) begin
                r = '0;
                if (x != 0) ovf = 1;
            end else begin
                p = x * (longint'(1) << c);
                r = p[RW-1:0];
                if (p > 32767 || p < -32768) ovf = 1;
            end
            if (i < LANES / 2) lo[i*RW +: RW] = r;
            else               hi[(i - LANES/2)*RW +: RW] = r;
            if (r[RW-1]) neg = 1;
            if (r != '0) zero = 0;
        end
    endtask

    task automatic compare(input logic [VW-1:0] vec, input int c, input string req);
        logic [VW-1:0] lo, hi;
        bit o, n, z;
        model(vec, c, lo, hi, o, n, z);
        chk(out_valid == 1'b1, req, "out_valid", 64'(out_valid), 64'd1);
        chk(out_lo == lo, req, "out_lo", 64'(out_lo), 64'(lo));
        chk(out_hi == hi, req, "out_hi", 64'(out_hi), 64'(hi));
        chk(flag_ovf == o, req, "flag_ovf", 64'(flag_ovf), 64'(o));
        chk(flag_neg == n, req, "flag_neg", 64'(flag_neg), 64'(n));
        chk(flag_zero == z, req, "flag_zero", 64'(flag_zero), 64'(z));
    endtask

    task automatic drive(input logic [VW-1:0] vec, input bit sel,
                         input int imm, input int rg);
        in_valid = 1'b1;
        in_vec   = vec;
        sel_reg  = sel;
        imm_cnt  = CNT_W'(imm);
        reg_cnt  = CNT_W'(rg);
    endtask

    // One isolated operation; c_eff is the count the bench expects to apply
    task automatic run_one(input logic [VW-1:0] vec, input bit sel, input int imm,
                           input int rg, input int c_eff, input string req);
        @(negedge clk); drive(vec, sel, imm, rg);
        @(negedge clk); in_valid = 1'b0;
        chk(out_valid == 1'b0, "R6", "early out_valid", 64'(out_valid), 64'd0);
        @(negedge clk); compare(vec, c_eff, req);
        @(negedge clk);
        chk(out_valid == 1'b0, "R6", "late out_valid", 64'(out_valid), 64'd0);
    endtask

    task automatic test_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R11", "reset out_valid", 64'(out_valid), 64'd0);
        chk(out_lo == '0 && out_hi == '0, "R11", "reset vectors", 64'(out_lo), 64'd0);
        chk(!flag_ovf && !flag_neg && !flag_zero, "R11", "reset flags",
            64'({flag_ovf, flag_neg, flag_zero}), 64'd0);
        rst = 1'b0;
    endtask

    task automatic test_zero_count();
        // R1: lanes 0x7F, 0x80, 0x01, 0xFF sign-extend only
        run_one(32'hFF01_807F, 1'b0, 0, 9, 0, "R1");
        // R5: distinct lanes land in their own slots
        run_one(32'h0403_0201, 1'b0, 0, 0, 0, "R5");
    endtask

    task automatic test_shift_patterns();
        run_one(32'hFF01_807F, 1'b0, 3, 0, 3, "R2");
        run_one(32'h9C33_C501, 1'b1, 0, 7, 7, "R2");
        run_one(32'h80_7F_80_7F, 1'b0, 8, 0, 8, "R8");   // count = LW, no overflow
        run_one(32'h0000_8000, 1'b0, 9, 0, 9, "R8");     // -128 << 9 overflows
        run_one(32'h0000_0001, 1'b0, 15, 0, 15, "R10");  // 1 into the sign bit
        run_one(32'h0000_0000, 1'b0, 5, 0, 5, "R9");
    endtask

    task automatic test_large_count();
        run_one(32'h0000_0000, 1'b0, 16, 0, 16, "R3");
        run_one(32'h5A00_0000, 1'b0, 16, 0, 16, "R3");
        run_one(32'hFF01_807F, 1'b1, 0, 63, 63, "R3");
    endtask

    task automatic test_select();
        // unselected register count would zero everything
        run_one(32'h1234_5678, 1'b0, 3, 20, 3, "R4");
        // unselected immediate count would zero everything
        run_one(32'h1234_5678, 1'b1, 40, 2, 2, "R4");
    endtask

    task automatic test_back_to_back();
        logic [VW-1:0] v0 = 32'h0102_0304;
        logic [VW-1:0] v1 = 32'hF0E0_D0C0;
        logic [VW-1:0] v2 = 32'h7F00_8001;
        @(negedge clk); drive(v0, 1'b0, 1, 0);
        @(negedge clk); drive(v1, 1'b1, 0, 12);
        @(negedge clk); drive(v2, 1'b0, 17, 0);
        compare(v0, 1, "R7");
        @(negedge clk); in_valid = 1'b0;
        compare(v1, 12, "R7");
        @(negedge clk); compare(v2, 17, "R7");
        @(negedge clk);
        chk(out_valid == 1'b0, "R7", "stream end", 64'(out_valid), 64'd0);
    endtask

    initial begin
        test_reset();
        test_zero_count();
        test_shift_patterns();
        test_large_count();
        test_select();
        test_back_to_back();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule